// File: doc/BRIEF.md
# Masked Sticky Interrupt Register

This block is a single 32-bit control word that sits at one offset in a graphics engine's register window. Two event lines come in from the engine: one says the command buffer has drained, the other says the engine has gone idle. Each line is watched for a rising edge. When the source is not blocked, that edge sets a sticky pending flag in the upper half of the word. The lower half holds one blocking bit per source. A 1 in a blocking bit suppresses that source, and reset sets every blocking bit.

Software reads the word to see which sources are pending. It clears a flag by writing a 1 to that flag's position. The spare bits between the two halves always read as ones, and the spare bits above the flags always read as zeros. Because of this, reading the word and writing the same value straight back clears every pending flag and leaves the blocking bits unchanged.

Two outputs report pending flags. A summary status output follows the flags in the same cycle. A registered interrupt output follows one cycle later.

Top module: `gfx_irq_ctl`

## Requirements
- R1: After reset, a read at offset 0x78 returns 0x0000FFFF, and both the summary output and the interrupt output are low.
- R2: Word bits 1:0 are read/write blocking bits. Bit 0 belongs to the command-buffer-empty source (event input bit 0) and bit 1 to the idle source (event input bit 1). A 1 blocks the source.
- R3: A rising edge on an unblocked event input sets its flag at word bit 16+i on that clock edge. An input that stays high does not set the flag again until it has fallen and risen once more.
- R4: An edge that arrives while its blocking bit is 1 sets no flag. A blocking bit written in a given cycle only applies to edges from the next cycle onward.
- R5: Writing a 1 to a flag bit clears that flag. Writing a 0 to a flag bit leaves it unchanged.
- R6: When an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R7: Setting a blocking bit after its flag is pending does not clear the flag.
- R8: Bits 31:18 always read as 0 and bits 15:2 always read as 1. Writes to these bits have no effect.
- R9: Reading the word and writing the same value back clears all pending flags and keeps the blocking bits.
- R10: The summary output is high in the same cycle any flag is high. The interrupt output goes high one clock after a flag sets and goes low one clock after the last flag clears.
- R11: A read at any other offset returns 0, and a write at any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 2 | Event levels: bit 0 = command buffer empty, bit 1 = engine idle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pend_sum_o | output | 1 | High while any flag is pending |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a write-one-to-clear that lands in exactly the same clock as a fresh rising edge on the same source. The stimulus table reaches it by pairing a clearing write with a low-to-high step on an event line in a single vector, so both arrive at one edge. The same table also holds event lines high across several clearing writes, which shows that a steady level does not set a flag again.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int REG_W    = 32;
  localparam int FLAG_LSB = 16;
  localparam int HI_RSVD  = REG_W - FLAG_LSB;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic rise_o,
  output logic set_o,
  output logic flag_o
);
  logic evt_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_i;
  end

  assign rise_o = evt_i & ~evt_q;
  assign set_o  = rise_o & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_o) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_ONE_SHOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o && !mask_i) |=> flag_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R7
  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && mask_i) |=> !flag_o); // R4
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import gfx_irq_pkg::*;
#(
  parameter int              NUM_SRC = 2,
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h78
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_SRC-1:0] flags_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               wr_hit_o,
  output logic [REG_W-1:0]   rdata_o
);
  logic rd_hit;
  logic [NUM_SRC-1:0] mask_q;

  function automatic logic [REG_W-1:0] pack_word(input logic [NUM_SRC-1:0] m,
                                                 input logic [NUM_SRC-1:0] f);
    logic [REG_W-1:0] w;
    w = '0;
    w[FLAG_LSB-1:0]        = '1;
    w[NUM_SRC-1:0]         = m;
    w[FLAG_LSB +: NUM_SRC] = f;
    return w;
  endfunction

  assign rd_hit   = (addr_i == REG_OFS);
  assign wr_hit_o = we_i && rd_hit;
  assign clr_o    = wr_hit_o ? wdata_i[FLAG_LSB +: NUM_SRC] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (wr_hit_o) mask_q <= wdata_i[NUM_SRC-1:0];
  end

  assign mask_o  = mask_q;
  assign rdata_o = rd_hit ? pack_word(mask_q, flags_i) : '0;

  always_comb begin
    if (rd_hit) begin
      AST_RSVD_LOW_ONES: assert (&rdata_o[FLAG_LSB-1:NUM_SRC]); // R8
      AST_RSVD_HIGH_ZERO: assert (rdata_o[REG_W-1:FLAG_LSB+NUM_SRC] == '0); // R8
    end else begin
      AST_MISS_READS_ZERO: assert (rdata_o == '0); // R11
    end
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_o |=> (mask_o == $past(wdata_i[NUM_SRC-1:0]))); // R2
  AST_MISS_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_o |=> $stable(mask_o)); // R11
endmodule

// File: rtl/gfx_irq_ctl.sv
module gfx_irq_ctl
  import gfx_irq_pkg::*;
#(
  parameter int              NUM_SRC = 2,
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h78
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               pend_sum_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_w;
  logic [NUM_SRC-1:0] clr_w;
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] set_w;
  logic [NUM_SRC-1:0] flag_w;
  logic               wr_hit_w;
  logic               irq_q;

  irq_reg_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr),
    .we_i     (bus_we),
    .wdata_i  (bus_wdata),
    .flags_i  (flag_w),
    .mask_o   (mask_w),
    .clr_o    (clr_w),
    .wr_hit_o (wr_hit_w),
    .rdata_o  (bus_rdata)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[g]),
      .mask_i (mask_w[g]),
      .clr_i  (clr_w[g]),
      .rise_o (rise_w[g]),
      .set_o  (set_w[g]),
      .flag_o (flag_w[g])
    );
  end

  assign pend_sum_o = |flag_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |flag_w;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    pend_sum_o |=> irq_o); // R10
  AST_IRQ_FALL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_sum_o |=> !irq_o); // R10
  AST_CLEAR_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit_w && pend_sum_o) |=> pend_sum_o); // R5
  AST_SET_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w == '0 && !pend_sum_o) |=> !pend_sum_o); // R3
  AST_SET_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w & ~rise_w) == '0); // R4
endmodule

// File: tb/test_gfx_irq_ctl.sv
`timescale 1ns/100ps
module test_gfx_irq_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  evt_i = 2'b00;
  logic [7:0]  bus_addr = 8'h78;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        pend_sum_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gfx_irq_ctl i_gfx_irq_ctl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_sum_o(pend_sum_o), .irq_o(irq_o)
  );

  // Vector fields: we | addr | wdata | evt | expected mask | expected flags
  localparam int NV = 15;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 8'h78, 32'h0000FFFC, 2'b00, 2'b00, 2'b00}, // R2 unblock both
    {1'b0, 8'h78, 32'h00000000, 2'b01, 2'b00, 2'b01}, // R3 cmd-empty edge
    {1'b1, 8'h78, 32'h0001FFFC, 2'b01, 2'b00, 2'b00}, // R3 R5 clear, level held
    {1'b0, 8'h78, 32'h00000000, 2'b00, 2'b00, 2'b00}, // R3 fall
    {1'b0, 8'h78, 32'h00000000, 2'b11, 2'b00, 2'b11}, // R3 both edges
    {1'b1, 8'h78, 32'h0000FFFC, 2'b11, 2'b00, 2'b11}, // R5 zeros keep flags
    {1'b1, 8'h78, 32'h0000FFFF, 2'b11, 2'b11, 2'b11}, // R7 block keeps flags
    {1'b1, 8'h78, 32'h0003FFFF, 2'b00, 2'b11, 2'b00}, // R5 clear both
    {1'b0, 8'h78, 32'h00000000, 2'b11, 2'b11, 2'b00}, // R4 blocked edges
    {1'b1, 8'h78, 32'h0000FFFE, 2'b00, 2'b10, 2'b00}, // R2 unblock bit0
    {1'b0, 8'h78, 32'h00000000, 2'b11, 2'b10, 2'b01}, // R4 only bit0 sets
    {1'b1, 8'h78, 32'h0000FFFC, 2'b00, 2'b00, 2'b01}, // R2 unblock all
    {1'b1, 8'h78, 32'h0003FFFC, 2'b10, 2'b00, 2'b10}, // R6 set with clear
    {1'b1, 8'h7C, 32'h0003FFFF, 2'b10, 2'b00, 2'b10}, // R11 miss write
    {1'b1, 8'h78, 32'hFFFC0000, 2'b10, 2'b00, 2'b10}  // R8 reserved writes
  };

  function automatic logic [31:0] expect_word(input logic [1:0] m, input logic [1:0] f);
    return {14'd0, f, 14'h3FFF, m};
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [1:0] e);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_i = e;
    @(posedge clk);
    #1;
    bus_we = 1'b0; bus_addr = 8'h78;
    #0.5;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1;
    check32("R1 reset word", bus_rdata, 32'h0000FFFF);
    check1("R1 summary", pend_sum_o, 1'b0);
    check1("R1 irq", irq_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][46], VEC[i][45:38], VEC[i][37:6], VEC[i][5:4]);
      check32($sformatf("vector %0d", i), bus_rdata, expect_word(VEC[i][3:2], VEC[i][1:0]));
    end

    // R11 read at another offset
    bus_addr = 8'h7C; #0.5;
    check32("R11 miss read", bus_rdata, 32'h0);
    bus_addr = 8'h78; #0.5;

    // R10 timing: clear all, then one fresh edge
    step(1'b1, 8'h78, 32'h0003FFFC, 2'b00);
    step(1'b0, 8'h78, 32'h0, 2'b00);
    check1("R10 irq low after clear", irq_o, 1'b0);
    step(1'b0, 8'h78, 32'h0, 2'b01);
    check1("R10 summary same cycle", pend_sum_o, 1'b1);
    check1("R10 irq not yet", irq_o, 1'b0);
    step(1'b0, 8'h78, 32'h0, 2'b01);
    check1("R10 irq one later", irq_o, 1'b1);

    // R9 read then write back
    step(1'b0, 8'h78, 32'h0, 2'b11);
    rd = bus_rdata;
    check32("R9 both pending", rd, 32'h0003FFFC);
    step(1'b1, 8'h78, rd, 2'b11);
    check32("R9 write-back clears", bus_rdata, 32'h0000FFFC);
    check1("R10 summary drops", pend_sum_o, 1'b0);
    step(1'b0, 8'h78, 32'h0, 2'b11);
    check1("R10 irq drops", irq_o, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule